// File: doc/BRIEF.md
# SLIP Packet Receive Parser

This block sits behind a byte-wide receive path and turns a SLIP-framed byte stream into decoded command packets. It first removes the SLIP framing and escape codes. It then reads a six-byte header and walks one or more chained field-descriptor bytes. From those it assembles typed fixed-size fields, which are 8, 16 or 32 bits wide and arrive little-endian. Each field is presented with the packet's device and command identifiers on a valid/ready output. Whatever follows the described fields is the payload blob, which streams out on its own byte channel with a final-byte marker.

When a frame closes, the block emits a one-cycle report. The report carries five error flags: length mismatch, checksum mismatch, bad escape code, reserved descriptor combination and oversized frame. Backpressure on either output stalls the byte input through `in_ready`, so nothing is dropped. Executing commands and storing the blob are left to the consumer.

Top module: `pkt_rx_parser`

## Requirements
- R1: The byte 0xC0 closes the current frame. Inside a frame, 0xDB then 0xDC gives a data byte 0xC0, and 0xDB then 0xDD gives a data byte 0xDB. Unescaping happens before decoding, so an escaped 0xC0 never ends a frame.
- R2: The unescaped bytes 0 to 5 of a frame are taken as: device ID, command ID, data length low byte, data length high byte, checksum, first descriptor. `out_dev` and `out_cmd` show the device and command bytes whenever a field is presented.
- R3: In a descriptor, bits [1:0] hold the field count minus one. Bit 7 gives the width of the first field and bits 6, 5 and 4 give the widths of the next ones, with 1 meaning 16 bits and 0 meaning 8 bits. `fld_wcode` is 0 for 8 bits, 1 for 16 bits and 2 for 32 bits. `fld_idx` counts fields from 0 in each frame and carries on across chained descriptors.
- R4: Descriptor bit 3 set makes every field of that descriptor 32 bits wide, whatever bits 7 to 4 hold.
- R5: Descriptor bit 2 set means the byte after that descriptor's last field is another descriptor, decoded the same way, with no limit on the chain.
- R6: Each field is assembled from its bytes in little-endian order and presented zero-extended on the 32-bit `fld_data`.
- R7: Every byte after the last described field is a blob byte. Blob bytes appear in order on the blob channel, and `blob_last` is set on the final one only. A frame without such bytes produces no blob output.
- R8: `frm_done` pulses for one cycle, one cycle after the closing 0xC0 is accepted, for every frame that held at least one byte. A frame holding no bytes produces no pulse. `frm_err` bits are: [0] length, [1] checksum, [2] escape, [3] reserved descriptor, [4] oversize.
- R9: `frm_err[1]` is set when the XOR of all frame bytes except byte 4 differs from byte 4.
- R10: `frm_err[0]` is set when the unescaped byte count differs from the data length plus 6. It is also set when the frame ends before its described fields are complete.
- R11: `frm_err[2]` is set when 0xDB is followed by any byte other than 0xDC or 0xDD. That pair yields no data byte.
- R12: `frm_err[3]` is set when a descriptor of the frame has bit 3 set together with a nonzero bits 7 to 4.
- R13: A frame of more than MAX_FRAME unescaped bytes sets `frm_err[4]` and also `frm_err[0]`.
- R14: While a presented field or blob byte is not accepted, it stays unchanged and `in_ready` is low. No byte or field is lost under any pattern of backpressure.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Raw stream byte present |
| in_data | input | 8 | Raw SLIP-encoded byte |
| in_ready | output | 1 | Block accepts the raw byte this cycle |
| out_dev | output | 8 | Device ID of the current packet |
| out_cmd | output | 8 | Command ID of the current packet |
| fld_valid | output | 1 | Decoded field present |
| fld_ready | input | 1 | Consumer takes the field |
| fld_data | output | 32 | Field value, zero-extended |
| fld_wcode | output | 2 | Field width code |
| fld_idx | output | IDX_W | Field position within the packet |
| blob_valid | output | 1 | Blob byte present |
| blob_ready | input | 1 | Consumer takes the blob byte |
| blob_data | output | 8 | Blob byte |
| blob_last | output | 1 | Final blob byte of the frame |
| frm_done | output | 1 | End-of-frame report pulse |
| frm_err | output | 5 | Error flags of the reported frame |

## Verification
The bench aims at payload bytes equal to 0xC0 and 0xDB, which are escaped on the wire. A design that unescaped after decoding would split those frames and report spurious length errors. Chained descriptors mixing 8-, 16- and 32-bit fields check byte order, the width bit taken for each field and the index carried across descriptors: a reversed bitmask or a big-endian assembly garbles the field values. The last blob byte must carry the final marker even though its position is known only when the frame closes, and a design that flagged it by count would lose it on frames with a wrong length. Random backpressure on both outputs checks that nothing is dropped or duplicated while the input is stalled. Directed frames with a corrupted checksum, a wrong length, a bad escape, a reserved descriptor, an oversize body and an empty frame must each raise exactly their own flags, or no report at all.

// File: rtl/pkt_rx_pkg.sv
package pkt_rx_pkg;
   localparam logic [7:0] SLIP_END  = 8'hC0;
   localparam logic [7:0] SLIP_ESC  = 8'hDB;
   localparam logic [7:0] SLIP_TEND = 8'hDC;
   localparam logic [7:0] SLIP_TESC = 8'hDD;

   localparam int HDR_BYTES = 6;
   localparam int ERR_W     = 5;
   localparam int E_LEN     = 0;
   localparam int E_CSUM    = 1;
   localparam int E_ESC     = 2;
   localparam int E_RSV     = 3;
   localparam int E_OVF     = 4;

   localparam logic [1:0] WC_8  = 2'd0;
   localparam logic [1:0] WC_16 = 2'd1;
   localparam logic [1:0] WC_32 = 2'd2;

   typedef enum logic [1:0] {PH_HDR, PH_DESC, PH_FLD, PH_BLOB} phase_t;
endpackage

// File: rtl/slip_unescape.sv
module slip_unescape
   import pkt_rx_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       take,
   input  logic [7:0] raw_byte,
   output logic       d_valid,
   output logic [7:0] d_byte,
   output logic       d_end,
   output logic       d_bad
);
   logic esc_q;

   always_comb begin
      d_valid = 1'b0;
      d_byte  = raw_byte;
      d_end   = 1'b0;
      d_bad   = 1'b0;
      if (take) begin
         if (raw_byte == SLIP_END) begin
            d_end = 1'b1;
            d_bad = esc_q;
         end else if (esc_q) begin
            if (raw_byte == SLIP_TEND) begin
               d_valid = 1'b1;
               d_byte  = SLIP_END;
            end else if (raw_byte == SLIP_TESC) begin
               d_valid = 1'b1;
               d_byte  = SLIP_ESC;
            end else begin
               d_bad = 1'b1;
            end
         end else if (raw_byte != SLIP_ESC) begin
            d_valid = 1'b1;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    esc_q <= 1'b0;
      else if (take) esc_q <= !esc_q && (raw_byte == SLIP_ESC);
   end
endmodule

// File: rtl/pkt_decode.sv
module pkt_decode
   import pkt_rx_pkg::*;
#(
   parameter int MAX_FRAME = 512,
   parameter int IDX_W     = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             d_valid,
   input  logic [7:0]       d_byte,
   input  logic             d_end,
   input  logic             d_bad,
   input  logic             fld_ready,
   input  logic             blob_ready,
   output logic             stall,
   output logic [7:0]       hdr_dev,
   output logic [7:0]       hdr_cmd,
   output logic             fld_valid,
   output logic [31:0]      fld_data,
   output logic [1:0]       fld_wcode,
   output logic [IDX_W-1:0] fld_idx,
   output logic             blob_valid,
   output logic [7:0]       blob_data,
   output logic             blob_last,
   output logic             frm_done,
   output logic [ERR_W-1:0] frm_err
);
   localparam int CNT_W = $clog2(MAX_FRAME + 2);
   localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(MAX_FRAME + 1);
   localparam logic [CNT_W-1:0] CSUM_POS = CNT_W'(4);

   phase_t           phase_q;
   logic [CNT_W-1:0] cnt_q;
   logic [15:0]      len_q;
   logic [7:0]       csum_q, xor_q;
   logic [3:0]       mask_q;
   logic             w32_q, more_q;
   logic [1:0]       last_slot_q, slot_q, bsel_q;
   logic [IDX_W-1:0] idx_q;
   logic             esc_seen_q, rsv_seen_q;
   logic             pend_v_q;
   logic [7:0]       pend_b_q;
   logic [7:0]       acc_q [4];
   logic [31:0]      word_c;
   logic [1:0]       last_b_c, wcode_c;
   logic             lane_wr, len_bad, ovf;

   assign stall    = (fld_valid && !fld_ready) || (blob_valid && !blob_ready);
   assign hdr_dev  = hdr_dev_q;
   assign hdr_cmd  = hdr_cmd_q;
   assign lane_wr  = d_valid && (phase_q == PH_FLD);
   assign wcode_c  = w32_q ? WC_32 : (mask_q[~slot_q] ? WC_16 : WC_8);
   assign last_b_c = w32_q ? 2'd3 : {1'b0, mask_q[~slot_q]};
   assign ovf      = (cnt_q == CNT_SAT);
   assign len_bad  = ovf || (phase_q != PH_BLOB) ||
                     (17'(cnt_q) != ({1'b0, len_q} + 17'(HDR_BYTES)));

   logic [7:0] hdr_dev_q, hdr_cmd_q;

   // one byte lane per field byte: capture and little-endian assembly
   for (genvar k = 0; k < 4; k++) begin : g_lane
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) acc_q[k] <= 8'h00;
         else if (lane_wr && (bsel_q == 2'(k))) acc_q[k] <= d_byte;
      end
      assign word_c[8*k +: 8] = (bsel_q > 2'(k))  ? acc_q[k] :
                                (bsel_q == 2'(k)) ? d_byte   : 8'h00;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= PH_HDR;       cnt_q <= '0;        len_q <= '0;
         csum_q <= '0;            xor_q <= '0;        mask_q <= '0;
         w32_q <= 1'b0;           more_q <= 1'b0;     last_slot_q <= '0;
         slot_q <= '0;            bsel_q <= '0;       idx_q <= '0;
         esc_seen_q <= 1'b0;      rsv_seen_q <= 1'b0; pend_v_q <= 1'b0;
         pend_b_q <= '0;          hdr_dev_q <= '0;    hdr_cmd_q <= '0;
         fld_valid <= 1'b0;       fld_data <= '0;     fld_wcode <= '0;
         fld_idx <= '0;           blob_valid <= 1'b0; blob_data <= '0;
         blob_last <= 1'b0;       frm_done <= 1'b0;   frm_err <= '0;
      end else begin
         frm_done <= 1'b0;
         if (fld_valid && fld_ready)   fld_valid  <= 1'b0;
         if (blob_valid && blob_ready) blob_valid <= 1'b0;
         if (d_bad) esc_seen_q <= 1'b1;

         if (d_valid) begin
            if (cnt_q != CNT_SAT)  cnt_q <= cnt_q + 1'b1;
            if (cnt_q != CSUM_POS) xor_q <= xor_q ^ d_byte;
            case (phase_q)
               PH_HDR: begin
                  if (cnt_q == CNT_W'(0))      hdr_dev_q   <= d_byte;
                  else if (cnt_q == CNT_W'(1)) hdr_cmd_q   <= d_byte;
                  else if (cnt_q == CNT_W'(2)) len_q[7:0]  <= d_byte;
                  else if (cnt_q == CNT_W'(3)) len_q[15:8] <= d_byte;
                  else begin
                     csum_q  <= d_byte;
                     phase_q <= PH_DESC;
                  end
               end
               PH_DESC: begin
                  mask_q      <= d_byte[7:4];
                  w32_q       <= d_byte[3];
                  more_q      <= d_byte[2];
                  last_slot_q <= d_byte[1:0];
                  slot_q      <= '0;
                  bsel_q      <= '0;
                  if (d_byte[3] && (d_byte[7:4] != 4'h0)) rsv_seen_q <= 1'b1;
                  phase_q     <= PH_FLD;
               end
               PH_FLD: begin
                  if (bsel_q == last_b_c) begin
                     fld_valid <= 1'b1;
                     fld_data  <= word_c;
                     fld_wcode <= wcode_c;
                     fld_idx   <= idx_q;
                     idx_q     <= idx_q + 1'b1;
                     bsel_q    <= '0;
                     if (slot_q == last_slot_q) phase_q <= more_q ? PH_DESC : PH_BLOB;
                     else                       slot_q  <= slot_q + 1'b1;
                  end else begin
                     bsel_q <= bsel_q + 1'b1;
                  end
               end
               default: begin
                  if (pend_v_q) begin
                     blob_valid <= 1'b1;
                     blob_data  <= pend_b_q;
                     blob_last  <= 1'b0;
                  end
                  pend_b_q <= d_byte;
                  pend_v_q <= 1'b1;
               end
            endcase
         end

         if (d_end) begin
            if (cnt_q != '0) begin
               frm_done       <= 1'b1;
               frm_err[E_LEN]  <= len_bad;
               frm_err[E_CSUM] <= (cnt_q > CSUM_POS) && (xor_q != csum_q);
               frm_err[E_ESC]  <= esc_seen_q || d_bad;
               frm_err[E_RSV]  <= rsv_seen_q;
               frm_err[E_OVF]  <= ovf;
            end
            if (pend_v_q) begin
               blob_valid <= 1'b1;
               blob_data  <= pend_b_q;
               blob_last  <= 1'b1;
               pend_v_q   <= 1'b0;
            end
            phase_q    <= PH_HDR;
            cnt_q      <= '0;
            xor_q      <= '0;
            len_q      <= '0;
            idx_q      <= '0;
            esc_seen_q <= 1'b0;
            rsv_seen_q <= 1'b0;
         end
      end
   end

   assert_fld_hold_R14: assert property (@(posedge clk) disable iff (!rst_n)
      fld_valid && !fld_ready |=> fld_valid && $stable(fld_data) && $stable(fld_idx));
   assert_blob_hold_R14: assert property (@(posedge clk) disable iff (!rst_n)
      blob_valid && !blob_ready |=> blob_valid && $stable(blob_data) && $stable(blob_last));
   assert_wcode_legal_R3: assert property (@(posedge clk) disable iff (!rst_n)
      fld_valid |-> fld_wcode != 2'd3);
   assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
      frm_done |=> !frm_done);
   assert_last_closes_R7: assert property (@(posedge clk) disable iff (!rst_n)
      blob_valid && blob_ready && blob_last |=> !blob_valid);
endmodule

// File: rtl/pkt_rx_parser.sv
module pkt_rx_parser
   import pkt_rx_pkg::*;
#(
   parameter int MAX_FRAME = 512,
   parameter int IDX_W     = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic [7:0]       in_data,
   output logic             in_ready,
   output logic [7:0]       out_dev,
   output logic [7:0]       out_cmd,
   output logic             fld_valid,
   input  logic             fld_ready,
   output logic [31:0]      fld_data,
   output logic [1:0]       fld_wcode,
   output logic [IDX_W-1:0] fld_idx,
   output logic             blob_valid,
   input  logic             blob_ready,
   output logic [7:0]       blob_data,
   output logic             blob_last,
   output logic             frm_done,
   output logic [4:0]       frm_err
);
   if (MAX_FRAME < HDR_BYTES + 1 || MAX_FRAME > 65535 + HDR_BYTES) begin : g_bad_frame
      $error("pkt_rx_parser: MAX_FRAME out of range");
   end
   if (IDX_W < 2 || IDX_W > 16) begin : g_bad_idx
      $error("pkt_rx_parser: IDX_W out of range");
   end

   logic       take, stall;
   logic       d_valid, d_end, d_bad;
   logic [7:0] d_byte;

   assign in_ready = !stall;
   assign take     = in_valid && in_ready;

   slip_unescape u_unesc (
      .clk      (clk),
      .rst_n    (rst_n),
      .take     (take),
      .raw_byte (in_data),
      .d_valid  (d_valid),
      .d_byte   (d_byte),
      .d_end    (d_end),
      .d_bad    (d_bad)
   );

   pkt_decode #(.MAX_FRAME(MAX_FRAME), .IDX_W(IDX_W)) u_dec (
      .clk        (clk),
      .rst_n      (rst_n),
      .d_valid    (d_valid),
      .d_byte     (d_byte),
      .d_end      (d_end),
      .d_bad      (d_bad),
      .fld_ready  (fld_ready),
      .blob_ready (blob_ready),
      .stall      (stall),
      .hdr_dev    (out_dev),
      .hdr_cmd    (out_cmd),
      .fld_valid  (fld_valid),
      .fld_data   (fld_data),
      .fld_wcode  (fld_wcode),
      .fld_idx    (fld_idx),
      .blob_valid (blob_valid),
      .blob_data  (blob_data),
      .blob_last  (blob_last),
      .frm_done   (frm_done),
      .frm_err    (frm_err)
   );
endmodule

// File: tb/pkt_rx_parser_tb.sv
module pkt_rx_parser_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [7:0]  in_data = 8'h00;
   logic        in_ready;
   logic [7:0]  out_dev, out_cmd;
   logic        fld_valid, fld_ready = 1'b1;
   logic [31:0] fld_data;
   logic [1:0]  fld_wcode;
   logic [7:0]  fld_idx;
   logic        blob_valid, blob_ready = 1'b1;
   logic [7:0]  blob_data;
   logic        blob_last;
   logic        frm_done;
   logic [4:0]  frm_err;

   pkt_rx_parser u_dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
      .in_ready(in_ready), .out_dev(out_dev), .out_cmd(out_cmd),
      .fld_valid(fld_valid), .fld_ready(fld_ready), .fld_data(fld_data),
      .fld_wcode(fld_wcode), .fld_idx(fld_idx), .blob_valid(blob_valid),
      .blob_ready(blob_ready), .blob_data(blob_data), .blob_last(blob_last),
      .frm_done(frm_done), .frm_err(frm_err)
   );

   always #2 clk = ~clk;

   int tests = 0, fails = 0;
   bit finished = 1'b0;
   bit bp = 1'b0;

   logic [7:0]  dq [$];
   logic [7:0]  tx_q [$];
   logic [31:0] ef_d [$];
   logic [1:0]  ef_w [$];
   logic [7:0]  eb [$];
   logic [31:0] gf_d [$];
   logic [1:0]  gf_w [$];
   logic [7:0]  gf_i [$];
   logic [7:0]  gb [$];
   int          done_n, last_n, devbad;
   logic [4:0]  got_err;
   logic [7:0]  cur_dev, cur_cmd;

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
      end
   endtask

   function automatic logic [7:0] rbyte();
      int r = $urandom % 5;
      if (r == 0) return 8'hC0;
      if (r == 1) return 8'hDB;
      return 8'($urandom);
   endfunction

   task automatic cycle();
      @(negedge clk);
      fld_ready  = bp ? 1'($urandom % 2) : 1'b1;
      blob_ready = bp ? 1'($urandom % 2) : 1'b1;
      #1;
      if (fld_valid && fld_ready) begin
         gf_d.push_back(fld_data);
         gf_w.push_back(fld_wcode);
         gf_i.push_back(fld_idx);
         if (out_dev != cur_dev || out_cmd != cur_cmd) devbad++;
      end
      if (blob_valid && blob_ready) begin
         gb.push_back(blob_data);
         if (blob_last) last_n++;
      end
      if (frm_done) begin
         done_n++;
         got_err = frm_err;
      end
      if (tx_q.size() > 0 && (!bp || ($urandom % 4) != 0)) begin
         in_valid = 1'b1;
         in_data  = tx_q[0];
         if (in_ready) void'(tx_q.pop_front());
      end else begin
         in_valid = 1'b0;
      end
   endtask

   // builds one packet from dq, encodes it onto tx_q and fills the expected queues
   task automatic build(input logic [7:0] dev, input logic [7:0] cmd, input int blen,
                        input logic [7:0] csum_flip, input int len_delta, input bit bad_esc);
      logic [7:0] body [$];
      logic [7:0] raw [$];
      logic [7:0] cs;
      logic [15:0] len;
      ef_d.delete(); ef_w.delete(); eb.delete();
      for (int i = 0; i < dq.size(); i++) begin
         logic [7:0] d = dq[i];
         d[2] = (i < dq.size() - 1);
         body.push_back(d);
         for (int s = 0; s <= int'(d[1:0]); s++) begin
            int wb = d[3] ? 4 : (d[7-s] ? 2 : 1);
            logic [31:0] v = 32'h0;
            for (int b = 0; b < wb; b++) begin
               logic [7:0] x = rbyte();
               v = v | (32'(x) << (8 * b));
               body.push_back(x);
            end
            ef_d.push_back(v);
            ef_w.push_back(d[3] ? 2'd2 : (d[7-s] ? 2'd1 : 2'd0));
         end
      end
      for (int i = 0; i < blen; i++) begin
         logic [7:0] x = rbyte();
         body.push_back(x);
         eb.push_back(x);
      end
      len = 16'(body.size() - 1 + len_delta);
      raw = '{dev, cmd, len[7:0], len[15:8], 8'h00};
      foreach (body[i]) raw.push_back(body[i]);
      cs = 8'h00;
      foreach (raw[i]) if (i != 4) cs = cs ^ raw[i];
      raw[4] = cs ^ csum_flip;
      cur_dev = dev;
      cur_cmd = cmd;
      tx_q.push_back(8'hC0);
      foreach (raw[i]) begin
         if (raw[i] == 8'hC0)      begin tx_q.push_back(8'hDB); tx_q.push_back(8'hDC); end
         else if (raw[i] == 8'hDB) begin tx_q.push_back(8'hDB); tx_q.push_back(8'hDD); end
         else tx_q.push_back(raw[i]);
      end
      if (bad_esc) begin tx_q.push_back(8'hDB); tx_q.push_back(8'h41); end
      tx_q.push_back(8'hC0);
   endtask

   task automatic run_check(input string req, input logic [4:0] exp_err, input int exp_done);
      bit ok;
      bit save_bp = bp;
      int bad_at;
      gf_d.delete(); gf_w.delete(); gf_i.delete(); gb.delete();
      done_n = 0; last_n = 0; devbad = 0; got_err = 5'h0;
      while (tx_q.size() > 0) cycle();
      bp = 1'b0;
      repeat (10) cycle();
      bp = save_bp;
      chk(done_n == exp_done, req, "frame reports", done_n, exp_done);
      if (exp_done > 0) chk(got_err == exp_err, req, "error flags", int'(got_err), int'(exp_err));
      ok = (gf_d.size() == ef_d.size());
      bad_at = -1;
      if (ok) foreach (ef_d[i])
         if (gf_d[i] != ef_d[i] || gf_w[i] != ef_w[i] || gf_i[i] != 8'(i)) begin
            ok = 1'b0;
            if (bad_at < 0) bad_at = i;
         end
      if (bad_at >= 0)
         chk(1'b0, req, $sformatf("field %0d value/width/index", bad_at),
             int'(gf_d[bad_at]), int'(ef_d[bad_at]));
      else
         chk(ok, req, "field count", gf_d.size(), ef_d.size());
      ok = (gb.size() == eb.size());
      if (ok) foreach (eb[i]) if (gb[i] != eb[i]) ok = 1'b0;
      chk(ok, $sformatf("%s R7", req), "blob bytes", gb.size(), eb.size());
      chk(last_n == (eb.size() > 0 ? 1 : 0), $sformatf("%s R7", req), "blob last marks",
          last_n, eb.size() > 0 ? 1 : 0);
      chk(devbad == 0, "R2", "device/command beside fields", devbad, 0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         fails++;
         tests++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20251));
      repeat (3) @(negedge clk);
      #1;
      chk(in_ready && !fld_valid && !blob_valid && !frm_done, "R14",
          "idle state in reset", {in_ready, fld_valid, blob_valid, frm_done}, 4'b1000);
      rst_n = 1'b1;
      repeat (2) cycle();

      // R6: four fields 16,8,16,8 bits, selected by bits 7..4 (R3)
      dq = '{8'hA3};
      build(8'h11, 8'h22, 3, 8'h00, 0, 1'b0);
      run_check("R3 R6", 5'h00, 1);

      // R4: all 32-bit fields
      dq = '{8'h01 | 8'h08};
      build(8'hC0, 8'hDB, 2, 8'h00, 0, 1'b0);
      run_check("R4 R1", 5'h00, 1);

      // R5: three chained descriptors, no blob
      dq = '{8'hC1, 8'h0A, 8'h00};
      build(8'h05, 8'h06, 0, 8'h00, 0, 1'b0);
      run_check("R5", 5'h00, 1);

      // R9: checksum corrupted
      dq = '{8'h42};
      build(8'h01, 8'h02, 4, 8'h01, 0, 1'b0);
      run_check("R9", 5'h02, 1);

      // R10: declared length one too large
      dq = '{8'h10};
      build(8'h03, 8'h04, 2, 8'h00, 1, 1'b0);
      run_check("R10", 5'h01, 1);

      // R11: escape followed by an illegal byte
      dq = '{8'h81};
      build(8'h07, 8'h08, 3, 8'h00, 0, 1'b1);
      run_check("R11", 5'h04, 1);

      // R12: reserved combination, widths still all 32 bits (R4)
      dq = '{8'h99};
      build(8'h09, 8'h0A, 1, 8'h00, 0, 1'b0);
      run_check("R12", 5'h08, 1);

      // R13: oversized frame
      dq = '{8'h00};
      build(8'h0B, 8'h0C, 520, 8'h00, 0, 1'b0);
      run_check("R13", 5'h11, 1);

      // R8: empty frame gives no report and no output
      ef_d.delete(); eb.delete();
      tx_q.push_back(8'hC0);
      tx_q.push_back(8'hC0);
      run_check("R8", 5'h00, 0);

      // R14: random packets under random backpressure
      bp = 1'b1;
      for (int f = 0; f < 40; f++) begin
         int nd = 1 + ($urandom % 3);
         dq.delete();
         for (int j = 0; j < nd; j++) begin
            logic [1:0] c = 2'($urandom);
            if (($urandom % 4) == 0) dq.push_back({4'h0, 2'b10, c});
            else                     dq.push_back({4'($urandom), 2'b00, c});
         end
         build(8'($urandom), 8'($urandom), $urandom % 6, 8'h00, 0, 1'b0);
         run_check("R14 R1", 5'h00, 1);
      end

      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule